// File: doc/BRIEF.md
# Dual-Mode Raster Scan Generator

This block drives a 640x480 raster display from a 16-bit-wide video memory. It runs the horizontal and vertical counters, produces the two sync pulses, reads video words through a synchronous read port, and turns each word into one-bit red, green and blue levels. Two display modes share one fetch register and one prefetch schedule. They differ only in how a fetched word becomes pixels.

In character mode the screen is a grid of 8x8 cells. Each 16-bit word holds a character code in its low byte and two colours in its high byte. A small computed glyph set supplies the pixel pattern. In bitmap mode each word holds sixteen consecutive pixels, and the leftmost pixel is the most significant bit. A mode register, written through a one-cycle write port, selects the mode. A new mode takes effect at the next frame boundary, so a frame is never split between modes. A global inverse input flips every visible colour. Blanked pixels are always black.

Top module: `vga_scan_gen`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks and a frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (800 and 525 by default). With default polarity, `hsync` is low for line positions H_ACTIVE+H_FP to H_ACTIVE+H_FP+H_SYNC-1 and `vsync` is low for lines V_ACTIVE+V_FP to V_ACTIVE+V_FP+V_SYNC-1. All outputs are registered and show the scan position one clock later.
- R2: During reset and until the first clock edge after it, `hsync` and `vsync` are high, the colours are 0, and no read is issued. The scan restarts at position 0 of the last blanking line, and character mode is active.
- R3: In bitmap mode (mode value 2), the pixel at column x of line y is bit 15-(x mod 16) of the word at address y*(H_ACTIVE/16) + x/16. A 1 gives white (all three channels 1) and a 0 gives black. If the high byte of word 0 is 0xF0, the first eight pixels of line 0 are four white then four black.
- R4: In character mode (mode value 0), the word for pixel (x,y) is at address (y/8)*(H_ACTIVE/8) + x/8. Its bits [7:0] are the character code. Glyph row r (r = y mod 8) is the code rotated left by r bits, and the glyph pixel is bit 7-(x mod 8) of that row. A glyph 1 drives red, green and blue with the inverted bits 14, 13 and 12 of the word. A glyph 0 drives them with bits 10, 9 and 8.
- R5: While `inverse` is 1, every visible colour is XORed with 1.
- R6: Outside the visible area all three colours are 0, whatever the value of `inverse`.
- R7: A mode write with data 0 or 2 is recorded and takes effect at the first pixel of the next frame. Writes of 1 or 3 are ignored. A write in the last clock of a frame governs the frame that starts next.
- R8: Exactly one read is issued per 8-pixel cell (character mode) or per 16-pixel group (bitmap mode) on each visible line. One more read is issued at the end of the last line of the frame. This gives V_ACTIVE*groups+1 reads per frame.
- R9: The read issued in the last group of a line addresses the first word of the next line. After the last visible line and after the last line of the frame, it addresses word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode value: 0 character, 2 bitmap |
| inverse | input | 1 | Inverts all visible colours |
| vram_rd_en | output | 1 | Video memory read request |
| vram_addr | output | ADDR_W | Video memory word address |
| vram_rdata | input | 16 | Read data, valid the clock after the request |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| red | output | 1 | Red level |
| green | output | 1 | Green level |
| blue | output | 1 | Blue level |

## Verification
The risky overlap is a mode write that lands in the last clock of a frame. In that same cycle the frame-boundary commit takes place, and the fetch of word 0 for the coming frame has already been issued under the old mode. The bench places a write of 0 exactly in that clock while a bitmap mode is still pending. A behavioural per-clock model then requires the next frame to be rendered entirely in character mode, from its first pixel on. The per-frame read count and the addresses of the line-end reads are also judged across that boundary.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
   typedef enum logic [1:0] {
      MODE_TEXT = 2'd0,
      MODE_BMP  = 2'd2
   } scan_mode_e;

   typedef logic [2:0] rgb_t;
endpackage

// File: rtl/vga_timing.sv
module vga_timing #(
   parameter int H_ACTIVE = 640,
   parameter int H_FP     = 16,
   parameter int H_SYNC   = 96,
   parameter int H_BP     = 48,
   parameter int V_ACTIVE = 480,
   parameter int V_FP     = 10,
   parameter int V_SYNC   = 2,
   parameter int V_BP     = 33,
   parameter int HW       = 10,
   parameter int VW       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [HW-1:0] hcnt,
   output logic [VW-1:0] vcnt,
   output logic          frame_end,
   output logic          visible,
   output logic          hs_act,
   output logic          vs_act
);
   localparam int H_TOT = H_ACTIVE + H_FP + H_SYNC + H_BP;
   localparam int V_TOT = V_ACTIVE + V_FP + V_SYNC + V_BP;
   localparam int HS_LO = H_ACTIVE + H_FP;
   localparam int VS_LO = V_ACTIVE + V_FP;

   logic h_end, v_end;
   int   h, v;

   always_comb begin
      h         = int'(hcnt);
      v         = int'(vcnt);
      h_end     = (h == H_TOT - 1);
      v_end     = (v == V_TOT - 1);
      frame_end = h_end && v_end;
      visible   = (h < H_ACTIVE) && (v < V_ACTIVE);
      hs_act    = (h >= HS_LO) && (h < HS_LO + H_SYNC);
      vs_act    = (v >= VS_LO) && (v < VS_LO + V_SYNC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= VW'(V_TOT - 1);
      end else if (h_end) begin
         hcnt <= '0;
         vcnt <= v_end ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      h_end |=> (hcnt == '0));
   a_r1_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !h_end |=> $stable(vcnt));
   a_r1_h_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(hcnt) < H_TOT);
endmodule

// File: rtl/vga_fetch.sv
module vga_fetch
   import vga_scan_pkg::*;
#(
   parameter int H_ACTIVE = 640,
   parameter int V_ACTIVE = 480,
   parameter int V_TOT    = 525,
   parameter int HW       = 10,
   parameter int VW       = 10,
   parameter int ADDR_W   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  scan_mode_e        mode,
   input  logic [HW-1:0]     hcnt,
   input  logic [VW-1:0]     vcnt,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [15:0]       rd_data,
   output logic [15:0]       word
);
   localparam int TXT_COLS = H_ACTIVE / 8;
   localparam int BMP_COLS = H_ACTIVE / 16;

   logic bmp, in_x, row_ok, last_grp, load;
   int   h, v, grp, ngrp, phase, lastph, nv, addr_i;

   function automatic int line_base(input logic is_bmp, input int line);
      return is_bmp ? line * BMP_COLS : (line / 8) * TXT_COLS;
   endfunction

   always_comb begin
      h        = int'(hcnt);
      v        = int'(vcnt);
      bmp      = (mode == MODE_BMP);
      lastph   = bmp ? 15 : 7;
      phase    = h & lastph;
      grp      = bmp ? h / 16 : h / 8;
      ngrp     = bmp ? BMP_COLS : TXT_COLS;
      in_x     = (h < H_ACTIVE);
      last_grp = (grp == ngrp - 1);
      row_ok   = (v < V_ACTIVE) || ((v == V_TOT - 1) && last_grp);
      nv       = (v >= V_ACTIVE - 1) ? 0 : v + 1;
      addr_i   = last_grp ? line_base(bmp, nv) : line_base(bmp, v) + grp + 1;
      rd_en    = in_x && row_ok && (phase == lastph - 1);
      load     = in_x && row_ok && (phase == lastph);
      rd_addr  = addr_i[ADDR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word <= '0;
      else if (load) word <= rd_data;
   end

   // R8: each read request is followed by the word capture one clock later
   a_r8_fetch_then_load: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> load);
   a_r8_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);
endmodule

// File: rtl/vga_pixel.sv
module vga_pixel
   import vga_scan_pkg::*;
#(
   parameter bit SYNC_ACTIVE_HIGH = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  scan_mode_e mode,
   input  logic [15:0] word,
   input  logic [3:0] xlo,
   input  logic [2:0] row,
   input  logic       visible,
   input  logic       inverse,
   input  logic       hs_act,
   input  logic       vs_act,
   output logic       hsync,
   output logic       vsync,
   output rgb_t       rgb
);
   localparam logic SYNC_IDLE = !SYNC_ACTIVE_HIGH;

   logic [7:0]  glyph;
   logic [15:0] dbl;
   logic        gpix, bpix, hs_lvl, vs_lvl;
   rgb_t        pix, rgb_nx;

   always_comb begin
      dbl   = {word[7:0], word[7:0]} << row;
      glyph = dbl[15:8];
   end

   always_comb begin
      gpix   = glyph[~xlo[2:0]];
      bpix   = word[~xlo];
      if (mode == MODE_BMP) pix = {3{bpix}};
      else                  pix = gpix ? ~word[14:12] : word[10:8];
      rgb_nx = visible ? (pix ^ {3{inverse}}) : '0;
   end

   if (SYNC_ACTIVE_HIGH) begin : g_sync_pos
      assign hs_lvl = hs_act;
      assign vs_lvl = vs_act;
   end else begin : g_sync_neg
      assign hs_lvl = ~hs_act;
      assign vs_lvl = ~vs_act;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync <= SYNC_IDLE;
         vsync <= SYNC_IDLE;
         rgb   <= '0;
      end else begin
         hsync <= hs_lvl;
         vsync <= vs_lvl;
         rgb   <= rgb_nx;
      end
   end
endmodule

// File: rtl/vga_scan_gen.sv
module vga_scan_gen
   import vga_scan_pkg::*;
#(
   parameter int H_ACTIVE = 640,
   parameter int H_FP     = 16,
   parameter int H_SYNC   = 96,
   parameter int H_BP     = 48,
   parameter int V_ACTIVE = 480,
   parameter int V_FP     = 10,
   parameter int V_SYNC   = 2,
   parameter int V_BP     = 33,
   parameter int ADDR_W   = 15,
   parameter bit SYNC_ACTIVE_HIGH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [1:0]        mode_wdata,
   input  logic              inverse,
   output logic              vram_rd_en,
   output logic [ADDR_W-1:0] vram_addr,
   input  logic [15:0]       vram_rdata,
   output logic              hsync,
   output logic              vsync,
   output logic              red,
   output logic              green,
   output logic              blue
);
   localparam int H_TOT = H_ACTIVE + H_FP + H_SYNC + H_BP;
   localparam int V_TOT = V_ACTIVE + V_FP + V_SYNC + V_BP;
   localparam int HW    = $clog2(H_TOT);
   localparam int VW    = $clog2(V_TOT);
   localparam int BMP_WORDS = (H_ACTIVE / 16) * V_ACTIVE;

   if (H_ACTIVE % 16 != 0) begin : g_bad_width
      $error("H_ACTIVE must be a multiple of 16");
   end
   if (V_ACTIVE % 8 != 0) begin : g_bad_height
      $error("V_ACTIVE must be a multiple of 8");
   end
   if (BMP_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the bitmap");
   end

   logic [HW-1:0] hcnt;
   logic [VW-1:0] vcnt;
   logic          frame_end, visible, hs_act, vs_act, wr_ok;
   logic [15:0]   word;
   scan_mode_e    mode_pend, mode_pend_nx, mode_act;
   rgb_t          rgb;

   vga_timing #(
      .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
      .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
      .HW(HW), .VW(VW)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
      .frame_end(frame_end), .visible(visible), .hs_act(hs_act), .vs_act(vs_act)
   );

   always_comb begin
      wr_ok        = mode_we && (mode_wdata == MODE_TEXT || mode_wdata == MODE_BMP);
      mode_pend_nx = wr_ok ? scan_mode_e'(mode_wdata) : mode_pend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_pend <= MODE_TEXT;
         mode_act  <= MODE_TEXT;
      end else begin
         mode_pend <= mode_pend_nx;
         if (frame_end) mode_act <= mode_pend_nx;
      end
   end

   vga_fetch #(
      .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .V_TOT(V_TOT),
      .HW(HW), .VW(VW), .ADDR_W(ADDR_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .mode(mode_act), .hcnt(hcnt), .vcnt(vcnt),
      .rd_en(vram_rd_en), .rd_addr(vram_addr), .rd_data(vram_rdata), .word(word)
   );

   vga_pixel #(.SYNC_ACTIVE_HIGH(SYNC_ACTIVE_HIGH)) u_pixel (
      .clk(clk), .rst_n(rst_n), .mode(mode_act), .word(word),
      .xlo(hcnt[3:0]), .row(vcnt[2:0]), .visible(visible), .inverse(inverse),
      .hs_act(hs_act), .vs_act(vs_act), .hsync(hsync), .vsync(vsync), .rgb(rgb)
   );

   assign {red, green, blue} = rgb;

   // R7: the displayed mode moves only at the frame boundary
   a_r7_mode_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(mode_act));
   a_r7_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_act == MODE_TEXT) || (mode_act == MODE_BMP));
   // R6: a pixel shown during a horizontal sync pulse is black
   a_r6_sync_black: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync == SYNC_ACTIVE_HIGH) |-> (rgb == 3'b000));
   // R9: no read while the frame is blanked outside the pre-frame line end
   a_r9_no_blank_read: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(vcnt) >= V_ACTIVE && int'(vcnt) < V_TOT - 1) |-> !vram_rd_en);
endmodule

// File: tb/sim_vga_scan_gen.sv
`timescale 1ns/1ps
module sim_vga_scan_gen;
   localparam int HA = 64, HF = 4, HS = 8, HB = 4;
   localparam int VA = 32, VF = 2, VS = 2, VB = 2;
   localparam int HT = HA + HF + HS + HB;
   localparam int VT = VA + VF + VS + VB;
   localparam int AW = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_we = 1'b0;
   logic [1:0]    mode_wdata = 2'd0;
   logic          inverse = 1'b0;
   logic          vram_rd_en;
   logic [AW-1:0] vram_addr;
   logic [15:0]   vram_rdata = 16'h0;
   logic          hsync, vsync, red, green, blue;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 1'b0, armed = 1'b0, full_frame = 1'b0;
   string ctx = "R2";

   // model state
   int bh, bv, pend, act, frame_reads;
   int e_x, e_y, e_mode;
   bit e_vis, e_inv, e_hs, e_vs;
   logic [2:0] e_rgb;

   always #2.5 clk = ~clk;

   vga_scan_gen #(
      .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
      .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .ADDR_W(AW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
      .inverse(inverse), .vram_rd_en(vram_rd_en), .vram_addr(vram_addr),
      .vram_rdata(vram_rdata), .hsync(hsync), .vsync(vsync),
      .red(red), .green(green), .blue(blue)
   );

   function automatic logic [15:0] ram_fn(input int a);
      logic [31:0] t;
      if (a == 0) return 16'hF0A5;
      t = a * 32'h9E37 ^ (a << 5) ^ 32'h3C1D;
      return t[15:0];
   endfunction

   function automatic logic [7:0] rotl(input logic [7:0] c, input int r);
      logic [7:0] o;
      o = c;
      for (int i = 0; i < r; i++) o = {o[6:0], o[7]};
      return o;
   endfunction

   function automatic int base_of(input int m, input int line);
      return (m == 2) ? line * (HA / 16) : (line / 8) * (HA / 8);
   endfunction

   // behavioural video memory with one clock of read latency
   always @(posedge clk) if (vram_rd_en) vram_rdata <= ram_fn(int'(vram_addr));

   // reference model, advanced on each rising edge
   always @(posedge clk) begin
      logic [15:0] w;
      logic [7:0]  gl;
      if (!rst_n) begin
         bh = 0; bv = VT - 1; pend = 0; act = 0;
         e_rgb = 3'b000; e_hs = 1'b1; e_vs = 1'b1; e_vis = 1'b0;
      end else begin
         e_x = bh; e_y = bv; e_mode = act; e_inv = inverse;
         e_vis = (bh < HA) && (bv < VA);
         e_hs = !(bh >= HA + HF && bh < HA + HF + HS);
         e_vs = !(bv >= VA + VF && bv < VA + VF + VS);
         if (!e_vis) e_rgb = 3'b000;
         else begin
            if (act == 2) begin
               w = ram_fn(bv * (HA / 16) + bh / 16);
               e_rgb = w[15 - bh % 16] ? 3'b111 : 3'b000;
            end else begin
               w = ram_fn((bv / 8) * (HA / 8) + bh / 8);
               gl = rotl(w[7:0], bv % 8);
               e_rgb = gl[7 - bh % 8] ? ~w[14:12] : w[10:8];
            end
            if (inverse) e_rgb = e_rgb ^ 3'b111;
         end
         if (mode_we && (mode_wdata == 2'd0 || mode_wdata == 2'd2)) pend = int'(mode_wdata);
         if (bh == HT - 1 && bv == VT - 1) act = pend;
         if (bh == HT - 1) begin
            bh = 0;
            bv = (bv == VT - 1) ? 0 : bv + 1;
         end else bh = bh + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (x=%0d y=%0d)", req, act_v, exp_v, e_x, e_y);
      end
   endtask

   // comparisons away from the active edge
   always @(negedge clk) begin
      if (armed && !done) begin
         string tag;
         int g, nv;
         if (!e_vis) tag = "R6";
         else if (e_inv) tag = "R5";
         else if (e_mode == 2) tag = "R3";
         else tag = "R4";
         check({red, green, blue} == e_rgb, {tag, "/", ctx}, {red, green, blue}, e_rgb);
         check(hsync == e_hs && vsync == e_vs, "R1 sync", {hsync, vsync}, {e_hs, e_vs});
         if (e_vis && e_mode == 2 && e_y == 0 && e_x < 8 && !e_inv)
            check({red, green, blue} == ((e_x < 4) ? 3'b111 : 3'b000), "R3 top-left byte",
                  {red, green, blue}, (e_x < 4) ? 7 : 0);
         g = (act == 2) ? 16 : 8;
         if (vram_rd_en) begin
            frame_reads++;
            if (bh >= HA - g && bh < HA) begin
               nv = (bv >= VA - 1) ? 0 : bv + 1;
               check(int'(vram_addr) == base_of(act, nv), "R9 line-end target",
                     int'(vram_addr), base_of(act, nv));
            end
         end
         if (bh == HT - 1 && bv == VT - 1) begin
            if (full_frame)
               check(frame_reads == VA * (HA / g) + 1, "R8 reads per frame",
                     frame_reads, VA * (HA / g) + 1);
            full_frame = 1'b1;
            frame_reads = 0;
         end
      end
   end

   task automatic wait_pos(input int x, input int y);
      do @(negedge clk); while (!(bh == x && bv == y));
   endtask

   task automatic write_mode(input logic [1:0] val);
      mode_we = 1'b1; mode_wdata = val;
      @(negedge clk);
      mode_we = 1'b0;
   endtask

   initial begin
      frame_reads = 0;
      repeat (4) @(negedge clk);
      // R2: reset levels
      check(hsync == 1'b1 && vsync == 1'b1, "R2 sync idle", {hsync, vsync}, 3);
      check({red, green, blue} == 3'b000, "R2 colours", {red, green, blue}, 0);
      check(vram_rd_en == 1'b0, "R2 no read", vram_rd_en, 0);
      rst_n = 1'b1;
      @(posedge clk);
      armed = 1'b1;
      ctx = "R2";
      // frame A: character mode, ignored writes mid-frame
      wait_pos(0, 0); ctx = "R4";
      wait_pos(10, 12); write_mode(2'd1);
      wait_pos(20, 12); write_mode(2'd3);
      // frame B: must still be character mode
      wait_pos(0, 0); ctx = "R7 ignored write";
      wait_pos(5, 9); write_mode(2'd2);
      // frame C: bitmap, inverse switched on halfway
      wait_pos(0, 0); ctx = "R3";
      wait_pos(0, 16); inverse = 1'b1; ctx = "R5";
      // frame D: bitmap inverted, write 0 in the final clock
      wait_pos(0, 0); ctx = "R5 bitmap";
      wait_pos(HT - 1, VT - 1); write_mode(2'd0);
      // frame E: character mode from the first pixel
      ctx = "R7 boundary write";
      wait_pos(0, 5); inverse = 1'b0;
      wait_pos(0, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 100000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule